// File: doc/BRIEF.md
# Down-Counting Timer Unit

This block holds several independent down-counting timer channels behind one small synchronous register port. Software loads a channel's counter and reload value, picks its count source in the channel's control word, and sets the channel's bit in the shared start word. On every tick of the chosen source the counter steps down by one. When a tick finds the counter already at zero, the reload value is loaded, the channel's underflow flag is set and counting goes on.

One channel also watches a capture input. A rising edge on that input copies the live counter into a capture register and sets a capture flag. Each flag, when its enable is set, raises an interrupt request. A fixed-priority encoder reports the most urgent pending request as a number, together with a valid bit.

A channel can be reconfigured only while it is stopped. The start word and flag clears are accepted at any time, and a flag clear touches nothing else. Reads have one cycle of latency. A counter read that lands on a count step returns the value from before the step.

Top module: `dtm_timer`

## Requirements
- R1: After a synchronous reset, every counter, reload, control, capture and start bit reads as zero, and no interrupt request, valid or id is asserted.
- R2: While channel c's start bit is set, its counter drops by one on each tick of its selected source. While that bit is clear, the counter does not change except by a register write.
- R3: A tick that finds the counter at zero loads the reload value in its place and sets the underflow flag (control bit 8). The channel keeps counting afterwards.
- R4: Control bits 2:0 with values 0, 1, 2 and 3 select a shared 8-bit prescaler, which reset clears and which advances on every clock. Value k ticks in each clock where the low 2k+2 prescaler bits are all ones, giving divide-by-4, 16, 64 and 256.
- R5: Control bits 2:0 with values 4 to 7 count rising edges of the external clock input. That input passes through a two-flop synchroniser and then an edge detector. It may toggle at most at one quarter of the clock rate.
- R6: A write to the counter, reload or control configuration of a channel whose start bit is set is dropped. The start word (address 0, bit c for channel c) is written at any time.
- R7: Flags are cleared by writing 0 and kept by writing 1, and software can never set them. A hardware set in the same clock as a clear wins. A control write to a running channel changes only the flags.
- R8: A read with rd_en presents its data on rdata after the next clock edge and holds it until the next read. A counter read in the same clock as a count step returns the value from before the step.
- R9: On a rising edge of the synchronised capture input, the capture channel copies its counter into its capture register and sets its capture flag (control bit 9). The copied value is the one from before any step in that clock. Other channels read 0 at these positions.
- R10: An irq_req bit is high exactly while its flag and its enable are both set. The underflow enable is control bit 5 and the capture enable is control bit 6 of the capture channel.
- R11: The request order, from most to least urgent, is: ch0 underflow, ch1 underflow, ch2 underflow, ch2 capture, ch3 underflow, ch4 underflow. That order also gives the bit positions in irq_req. irq_valid is high when any request is pending, and irq_id then gives the index of the first pending request in that order.
- R12: Address map, word addressed. Address 0 is the start word. Channel c sits at 4*(c+1), with offset +0 the counter, +1 the reload, +2 the control word and +3 the capture register. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| irq_req | output | NUM_CH+1 | Per-source interrupt requests in priority order |
| irq_valid | output | 1 | Some request is pending |
| irq_id | output | clog2(NUM_CH+1) | Index of the most urgent pending request |

## Verification
A wrong counter, reload or configuration state becomes visible on rdata one clock after a read of that channel. Flag state shows on irq_req and irq_id in the same clock it changes, as long as the enables are set. A tick source with the wrong phase or rate leaves the counter out of step with a cycle-exact reference within one divide period. A dropped write protection or a flag clear that disturbs other bits shows up on the next read of the control word. A late capture shows up as a capture value one step off.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    // Prescaler: stage k divides the clock by 4^(k+1)
    localparam int PRE_STAGES = 4;
    localparam int PRE_W      = 2 * PRE_STAGES;

    // Control word layout
    localparam int SEL_W     = 3;
    localparam int F_SEL_LSB = 0;
    localparam int F_UIE     = 5;
    localparam int F_CIE     = 6;
    localparam int F_UNF     = 8;
    localparam int F_CAPF    = 9;
    localparam int CTRL_W    = 10;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_CAPT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic             unf_ie;
        logic             cap_ie;
    } chan_cfg_t;

    typedef struct packed {
        logic unf;
        logic capf;
    } chan_flags_t;

    // Interrupt source index of channel ch's underflow
    function automatic int unf_src(input int ch, input int cap_ch);
        return (ch > cap_ch) ? ch + 1 : ch;
    endfunction

    // Interrupt source index of the capture event
    function automatic int cap_src(input int cap_ch);
        return cap_ch + 1;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input chan_cfg_t c, input chan_flags_t f);
        logic [CTRL_W-1:0] v;
        v                        = '0;
        v[F_SEL_LSB +: SEL_W]    = c.clk_sel;
        v[F_UIE]                 = c.unf_ie;
        v[F_CIE]                 = c.cap_ie;
        v[F_UNF]                 = f.unf;
        v[F_CAPF]                = f.capf;
        return v;
    endfunction

endpackage

// File: rtl/dtm_edge_sync.sv
module dtm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // sh_q[0], sh_q[1]: synchroniser; sh_q[2]: edge history
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], async_i};
    end

    assign rise_o = sh_q[1] & ~sh_q[2];

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dtm_clkgen.sv
module dtm_clkgen
    import dtm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ext_i,
    input  logic                  cap_i,
    output logic [PRE_STAGES-1:0] tick_o,
    output logic                  ext_rise_o,
    output logic                  cap_rise_o
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k < PRE_STAGES; k++) begin : g_tick
        assign tick_o[k] = &pre_q[2*k+1:0];
    end

    dtm_edge_sync u_ext (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_i),
        .rise_o  (ext_rise_o)
    );

    dtm_edge_sync u_cap (
        .clk     (clk),
        .rst     (rst),
        .async_i (cap_i),
        .rise_o  (cap_rise_o)
    );

endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter bit HAS_CAP = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic [PRE_STAGES-1:0] tick_pre_i,
    input  logic                  ext_rise_i,
    input  logic                  cap_rise_i,
    input  logic                  wr_i,
    input  reg_sel_e              wr_reg_i,
    input  logic [CNT_W-1:0]      wdata_i,
    output logic [CNT_W-1:0]      count_o,
    output logic [CNT_W-1:0]      reload_o,
    output logic [CNT_W-1:0]      capt_o,
    output chan_cfg_t             cfg_o,
    output chan_flags_t           flags_o
);
    logic [CNT_W-1:0] count_q, reload_q;
    chan_cfg_t        cfg_q;
    logic             unf_q;
    logic             capf_w;

    logic tick_sel, step, at_zero, unf_hit;
    logic ctrl_wr, wr_cnt, wr_rel, wr_cfg, keep_unf;

    assign tick_sel = cfg_q.clk_sel[SEL_W-1] ? ext_rise_i : tick_pre_i[cfg_q.clk_sel[1:0]];
    assign step     = run_i & tick_sel;
    assign at_zero  = (count_q == '0);
    assign unf_hit  = step & at_zero;

    assign ctrl_wr  = wr_i && (wr_reg_i == REG_CTRL);
    assign wr_cnt   = wr_i && (wr_reg_i == REG_COUNT)  && !run_i;
    assign wr_rel   = wr_i && (wr_reg_i == REG_RELOAD) && !run_i;
    assign wr_cfg   = ctrl_wr && !run_i;
    assign keep_unf = !(ctrl_wr && !wdata_i[F_UNF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            cfg_q    <= '0;
            unf_q    <= 1'b0;
        end else begin
            if (step)        count_q <= at_zero ? reload_q : count_q - 1'b1;
            else if (wr_cnt) count_q <= wdata_i;
            if (wr_rel) reload_q <= wdata_i;
            if (wr_cfg) begin
                cfg_q.clk_sel <= wdata_i[F_SEL_LSB +: SEL_W];
                cfg_q.unf_ie  <= wdata_i[F_UIE];
                cfg_q.cap_ie  <= HAS_CAP ? wdata_i[F_CIE] : 1'b0;
            end
            unf_q <= unf_hit | (unf_q & keep_unf);
        end
    end

    if (HAS_CAP) begin : g_cap
        logic [CNT_W-1:0] capt_q;
        logic             capf_q;
        logic             keep_cap;

        assign keep_cap = !(ctrl_wr && !wdata_i[F_CAPF]);

        always_ff @(posedge clk) begin
            if (rst) begin
                capt_q <= '0;
                capf_q <= 1'b0;
            end else begin
                if (cap_rise_i) capt_q <= count_q;
                capf_q <= cap_rise_i | (capf_q & keep_cap);
            end
        end

        assign capt_o = capt_q;
        assign capf_w = capf_q;

        // R9
        capture_value_chk: assert property (@(posedge clk) disable iff (rst)
            cap_rise_i |=> (capt_q == $past(count_q)) && capf_q);
    end else begin : g_nocap
        logic unused_cap;
        assign unused_cap = cap_rise_i;
        assign capt_o     = '0;
        assign capf_w     = 1'b0;
    end

    assign count_o      = count_q;
    assign reload_o     = reload_q;
    assign cfg_o        = cfg_q;
    assign flags_o.unf  = unf_q;
    assign flags_o.capf = capf_w;

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !tick_sel) |=> $stable(count_q));

    // R3
    underflow_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_sel && count_q == '0) |=> (count_q == $past(reload_q)) && unf_q);

    // R6
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |=> $stable(cfg_q) && $stable(reload_q));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata_i[F_UNF] && !unf_hit) |=> !unf_q);

endmodule

// File: rtl/dtm_prio.sv
module dtm_prio #(
    parameter int N    = 6,
    parameter int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req_i,
    output logic            valid_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        id_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = ID_W'(i);
        end
    end

    assign valid_o = |req_i;

    // R11
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> req_i[id_o]);

    // R11
    no_higher_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((req_i & ((N'(1) << id_o) - N'(1))) == '0));

endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
    import dtm_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 32,
    parameter int CAP_CH = 2,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [CNT_W-1:0]             wdata,
    output logic [CNT_W-1:0]             rdata,
    input  logic                         ext_clk_in,
    input  logic                         cap_in,
    output logic [NUM_CH:0]              irq_req,
    output logic                         irq_valid,
    output logic [$clog2(NUM_CH+1)-1:0]  irq_id
);
    localparam int CH_IDX_W = ADDR_W - 2;
    localparam int NUM_SRC  = NUM_CH + 1;
    localparam int ID_W     = $clog2(NUM_SRC);

    logic [CH_IDX_W-1:0]   ch_idx;
    reg_sel_e              reg_sel;
    logic [NUM_CH-1:0]     start_q;
    logic [CNT_W-1:0]      rdata_q, rd_mux;
    logic [PRE_STAGES-1:0] pre_tick;
    logic                  ext_rise, cap_rise;

    logic [CNT_W-1:0] cnt_w  [NUM_CH];
    logic [CNT_W-1:0] rel_w  [NUM_CH];
    logic [CNT_W-1:0] capt_w [NUM_CH];
    chan_cfg_t        cfg_w  [NUM_CH];
    chan_flags_t      flg_w  [NUM_CH];

    assign ch_idx  = addr[ADDR_W-1:2];
    assign reg_sel = reg_sel_e'(addr[1:0]);

    dtm_clkgen u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .ext_i      (ext_clk_in),
        .cap_i      (cap_in),
        .tick_o     (pre_tick),
        .ext_rise_o (ext_rise),
        .cap_rise_o (cap_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = wr_en && (ch_idx == CH_IDX_W'(c + 1));

        dtm_channel #(
            .CNT_W   (CNT_W),
            .HAS_CAP (c == CAP_CH)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .run_i      (start_q[c]),
            .tick_pre_i (pre_tick),
            .ext_rise_i (ext_rise),
            .cap_rise_i (cap_rise),
            .wr_i       (sel_me),
            .wr_reg_i   (reg_sel),
            .wdata_i    (wdata),
            .count_o    (cnt_w[c]),
            .reload_o   (rel_w[c]),
            .capt_o     (capt_w[c]),
            .cfg_o      (cfg_w[c]),
            .flags_o    (flg_w[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                      start_q <= '0;
        else if (wr_en && addr == '0) start_q <= wdata[NUM_CH-1:0];
    end

    always_comb begin
        rd_mux = '0;
        if (addr == '0) rd_mux[NUM_CH-1:0] = start_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_IDX_W'(c + 1)) begin
                case (reg_sel)
                    REG_COUNT:  rd_mux = cnt_w[c];
                    REG_RELOAD: rd_mux = rel_w[c];
                    REG_CTRL:   rd_mux = CNT_W'(pack_ctrl(cfg_w[c], flg_w[c]));
                    default:    rd_mux = capt_w[c];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    always_comb begin
        irq_req = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            irq_req[unf_src(c, CAP_CH)] = flg_w[c].unf & cfg_w[c].unf_ie;
        end
        irq_req[cap_src(CAP_CH)] = flg_w[CAP_CH].capf & cfg_w[CAP_CH].cap_ie;
    end

    dtm_prio #(
        .N    (NUM_SRC),
        .ID_W (ID_W)
    ) u_prio (
        .clk     (clk),
        .rst     (rst),
        .req_i   (irq_req),
        .valid_o (irq_valid),
        .id_o    (irq_id)
    );

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_q));

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0) |=> (start_q == $past(wdata[NUM_CH-1:0])));

endmodule

// File: tb/dtm_timer_tb.sv
module dtm_timer_tb_top;
    localparam int NUM_CH     = 5;
    localparam int CNT_W      = 32;
    localparam int CAP_CH     = 2;
    localparam int ADDR_W     = 5;
    localparam int NSRC       = NUM_CH + 1;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, ext_in = 1'b0, cap_in = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [NSRC-1:0]   irq_req;
    logic              irq_valid;
    logic [2:0]        irq_id;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtm_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CAP_CH(CAP_CH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk_in(ext_in), .cap_in(cap_in), .irq_req(irq_req),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    // ---------------- reference model of the requirements ----------------
    logic [31:0]       m_cnt [NUM_CH];
    logic [31:0]       m_rel [NUM_CH];
    logic [31:0]       m_capt[NUM_CH];
    logic [2:0]        m_sel [NUM_CH];
    logic              m_uie [NUM_CH];
    logic              m_cie [NUM_CH];
    logic              m_unf [NUM_CH];
    logic              m_capf[NUM_CH];
    logic [NUM_CH-1:0] m_start;
    logic [7:0]        m_pre;
    logic [2:0]        m_es, m_cs;
    logic [31:0]       m_rdata;

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        logic [31:0] v;
        v = '0;
        if (a == '0) v[NUM_CH-1:0] = m_start;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(a[4:2]) == c + 1) begin
                case (a[1:0])
                    2'd0: v = m_cnt[c];
                    2'd1: v = m_rel[c];
                    2'd2: v = {22'd0, m_capf[c], m_unf[c], 1'b0, m_cie[c], m_uie[c], 2'b00, m_sel[c]};
                    default: v = m_capt[c];
                endcase
            end
        end
        return v;
    endfunction

    function automatic logic [NSRC-1:0] model_req();
        logic [NSRC-1:0] r;
        r = '0;
        for (int c = 0; c < NUM_CH; c++) r[(c > CAP_CH) ? c + 1 : c] = m_unf[c] & m_uie[c];
        r[CAP_CH+1] = m_capf[CAP_CH] & m_cie[CAP_CH];
        return r;
    endfunction

    always @(posedge clk) begin
        logic er, cr;
        logic [3:0] pt;
        logic [NUM_CH-1:0] st;
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_cnt[c] = '0; m_rel[c] = '0; m_capt[c] = '0; m_sel[c] = '0;
                m_uie[c] = 1'b0; m_cie[c] = 1'b0; m_unf[c] = 1'b0; m_capf[c] = 1'b0;
            end
            m_start = '0; m_pre = '0; m_es = '0; m_cs = '0; m_rdata = '0;
        end else begin
            er = m_es[1] & ~m_es[2];
            cr = m_cs[1] & ~m_cs[2];
            m_es = {m_es[1:0], ext_in};
            m_cs = {m_cs[1:0], cap_in};
            for (int k = 0; k < 4; k++) begin
                logic [7:0] mk;
                mk = 8'((1 << (2*k + 2)) - 1);
                pt[k] = ((m_pre & mk) == mk);
            end
            m_pre = m_pre + 8'd1;
            if (rd_en) m_rdata = model_read(addr);
            st = m_start;
            for (int c = 0; c < NUM_CH; c++) begin
                logic tk, hit, cw, run;
                logic [ADDR_W-1:0] base;
                run  = st[c];
                tk   = m_sel[c][2] ? er : pt[m_sel[c][1:0]];
                hit  = run && tk && (m_cnt[c] == 0);
                base = ADDR_W'(4 * (c + 1));
                cw   = wr_en && (addr == base + 2);
                if (c == CAP_CH && cr) m_capt[c] = m_cnt[c];
                if (run && tk) m_cnt[c] = hit ? m_rel[c] : m_cnt[c] - 1;
                else if (wr_en && addr == base && !run) m_cnt[c] = wdata;
                if (wr_en && addr == base + 1 && !run) m_rel[c] = wdata;
                m_unf[c]  = hit | (m_unf[c] & !(cw && !wdata[8]));
                m_capf[c] = (c == CAP_CH && cr) | (m_capf[c] & !(cw && !wdata[9]));
                if (cw && !run) begin
                    m_sel[c] = wdata[2:0];
                    m_uie[c] = wdata[5];
                    m_cie[c] = (c == CAP_CH) ? wdata[6] : 1'b0;
                end
            end
            if (wr_en && addr == '0) m_start = wdata[NUM_CH-1:0];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int ra(input int c, input int r);
        return 4 * (c + 1) + r;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string tag, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
        chk(rdata == m_rdata, tag, $sformatf("read addr %0d vs model", a), rdata, m_rdata);
    endtask

    function automatic string tag_of(input int a);
        if (a < 4) return "R6";
        case (a % 4)
            0: return "R2";
            1: return "R8";
            2: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk_irq();
        logic [NSRC-1:0] er;
        logic [2:0] eid;
        er  = model_req();
        eid = '0;
        for (int i = NSRC - 1; i >= 0; i--) if (er[i]) eid = 3'(i);
        chk(irq_req == er, "R10", "irq_req", 32'(irq_req), 32'(er));
        chk(irq_valid == (|er), "R11", "irq_valid", 32'(irq_valid), 32'(|er));
        if (|er) chk(irq_id == eid, "R11", "irq_id", 32'(irq_id), 32'(eid));
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 24; a++) begin
            rd(a, "R1", v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(irq_valid == 1'b0 && irq_req == '0, "R1", "no irq after reset", 32'(irq_req), 0);

        // R12 map and plain write/readback while stopped
        wr(ra(0, 0), 5); wr(ra(0, 1), 3); wr(ra(0, 2), 32'h20);
        rd(ra(0, 0), "R12", v); chk(v == 5, "R12", "counter offset", v, 5);
        rd(ra(0, 1), "R12", v); chk(v == 3, "R12", "reload offset", v, 3);
        rd(ra(0, 2), "R12", v); chk(v == 32'h20, "R12", "control offset", v, 32'h20);

        // R6 write to running counter dropped
        wr(0, 32'h1);
        wr(ra(0, 0), 100);
        rd(ra(0, 0), "R6", v); chk(v != 100, "R6", "running counter write dropped", v, 100);

        // R3 underflow raises flag and id 0
        for (int i = 0; i < 200 && !irq_valid; i++) @(negedge clk);
        chk(irq_valid && irq_id == 0, "R3", "underflow irq ch0", 32'(irq_id), 0);
        chk_irq();
        rd(ra(0, 2), "R3", v); chk(v[8] == 1'b1, "R3", "underflow flag", v, 32'h120);

        // R7 clear while running keeps config
        wr(ra(0, 2), 32'h0);
        rd(ra(0, 2), "R7", v); chk((v & 32'h27) == 32'h20, "R7", "config kept on clear", v, 32'h20);

        // R8 back-to-back reads of a running counter
        for (int i = 0; i < 6; i++) rd(ra(0, 0), "R8", v);

        // R5 external edges on ch1
        wr(0, 32'h0);
        wr(ra(1, 0), 10); wr(ra(1, 2), 32'h4);
        wr(0, 32'h2);
        for (int i = 0; i < 3; i++) begin
            ext_in = 1'b1; repeat (4) @(negedge clk);
            ext_in = 1'b0; repeat (4) @(negedge clk);
        end
        rd(ra(1, 0), "R5", v); chk(v == 7, "R5", "three external edges", v, 7);

        // R11 / R9 priority of capture over ch3 underflow
        wr(0, 32'h0);
        wr(ra(0, 2), 0); wr(ra(1, 2), 0);
        wr(ra(3, 0), 0); wr(ra(3, 1), 0); wr(ra(3, 2), 32'h20);
        wr(ra(2, 0), 500); wr(ra(2, 2), 32'h40);
        wr(0, 32'hC);
        repeat (8) @(negedge clk);
        cap_in = 1'b1; repeat (4) @(negedge clk);
        cap_in = 1'b0; repeat (4) @(negedge clk);
        chk(irq_valid && irq_id == 3, "R11", "capture outranks ch3", 32'(irq_id), 3);
        chk_irq();
        rd(ra(2, 3), "R9", v); chk(v != 0 && v <= 500, "R9", "capture value", v, 500);
        rd(ra(2, 2), "R9", v); chk(v == 32'h240, "R9", "capture flag set", v, 32'h240);
        wr(ra(2, 2), 32'h0);
        chk(irq_valid && irq_id == 4, "R11", "ch3 after capture clear", 32'(irq_id), 4);
        rd(ra(2, 2), "R7", v); chk(v == 32'h40, "R7", "only capture flag cleared", v, 32'h40);
        rd(ra(1, 3), "R9", v); chk(v == 0, "R9", "non-capture channel reads 0", v, 0);

        // R4 slowest prescaler on ch4
        wr(0, 32'h0);
        wr(ra(4, 0), 2); wr(ra(4, 1), 2); wr(ra(4, 2), 32'h23);
        wr(0, 32'h10);
        for (int i = 0; i < 8; i++) begin
            repeat (150) @(negedge clk);
            rd(ra(4, 0), "R4", v);
            chk_irq();
        end

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int op, c, r;
            logic [31:0] d;
            if ($urandom % 3 == 0) ext_in = ~ext_in;
            if ($urandom % 7 == 0) cap_in = ~cap_in;
            op = $urandom % 10;
            c  = $urandom % NUM_CH;
            r  = $urandom % 4;
            if (op == 0) begin
                wr(0, 32'($urandom % 32));
            end else if (op < 5) begin
                d = (r == 2) ? ($urandom & 32'h367) : 32'($urandom % 48);
                wr(ra(c, r), d);
            end else if (op < 9) begin
                rd(ra(c, r), tag_of(ra(c, r)), v);
            end else begin
                repeat (($urandom % 3) + 1) @(negedge clk);
            end
            chk_irq();
        end
        rd(0, "R6", v);

        done = 1'b1;
        report();
        $finish;
    end

endmodule